// File: doc/BRIEF.md
# Exception Priority Resolver with Vectoring

This block selects which pending exception a small CPU with a 16-bit address space should take next, and gives the address of the vector for that exception. Six sources cannot be masked by the I bit: three reset causes, an illegal-opcode trap, a software interrupt and an external interrupt that only the X bit gates. Five further sources each have their own local enable and are masked by the I bit: an external interrupt line, a real-time tick and three timer channels.

The maskable sources follow a fixed default order. A byte register holds the low byte of one maskable vector, and the source it names moves above the other four. That register can be written only while the I bit is 1. The winner is found in combinational logic. The valid flag, the reset-class flag and the vector address are registered, so they follow the sampled inputs by one clock. The CPU reads the vector contents and does the stacking; both are outside this block.

Top module: `exc_resolver`

## Requirements
- R1: After reset, `exc_valid`, `exc_is_reset` and `exc_vector` are 0. The promote register holds 8'hF2, so the maskable order is the default one.
- R2: Non-maskable requests on `nmi_req` bits 0 to 5 have fixed priority, with bit 0 highest. Bit 0 is power-on/pin reset, bit 1 clock-monitor reset, bit 2 watchdog reset, bit 3 trap, bit 4 software interrupt and bit 5 the X-gated interrupt. Their vectors are 16'hFFFE, FFFC, FFFA, FFF8, FFF6 and FFF4.
- R3: `nmi_req[5]` is taken only when `mask_x` is 0.
- R4: A maskable request `irq_req[k]` is taken only when `mask_i` is 0 and `irq_en[k]` is 1. `mask_i` has no effect on `nmi_req`.
- R5: With the default order, the maskable priority runs from `irq_req` bit 0 (highest) to bit 4. Bit 0 is the external line, bit 1 the real-time tick and bits 2 to 4 the timer channels 0 to 2. Their vectors are 16'hFFF2, FFF0, FFEE, FFEC and FFEA.
- R6: When the promote register holds the low byte of a maskable vector (F2, F0, EE, EC or EA), that source outranks all other maskable sources. The rest keep their order, and every source keeps its own vector.
- R7: A promote value that matches none of the five low bytes gives the default order.
- R8: A write (`elev_we`=1) takes effect at the clock edge only if `mask_i` is 1 at that edge. Otherwise the write is ignored.
- R9: Any taken non-maskable request beats every maskable request, whatever the promote register holds.
- R10: `exc_is_reset` is 1 exactly when the winner is one of `nmi_req` bits 0 to 2.
- R11: The outputs show the decision for the inputs sampled at the previous rising clock edge. With no winner, `exc_valid` and `exc_vector` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 6 | Non-maskable requests, bit 0 highest |
| irq_req | input | 5 | Maskable requests |
| irq_en | input | 5 | Local enables of maskable requests |
| mask_i | input | 1 | CPU global interrupt mask |
| mask_x | input | 1 | CPU mask for nmi_req[5] |
| elev_we | input | 1 | Promote-register write strobe |
| elev_wdata | input | 8 | Promote-register write data |
| exc_valid | output | 1 | A request won |
| exc_is_reset | output | 1 | Winner is a reset cause |
| exc_vector | output | 16 | Vector address of the winner |

## Verification
The hardest case to reach from the ports is promotion while maskable requests are live. The promote register can only be loaded with `mask_i`=1, but promotion has no visible effect until `mask_i` has later dropped to 0. The random stimulus therefore toggles `mask_i` from step to step and issues writes often, so promote values written under a set mask stay in force through later unmasked steps. Directed steps add a valid promotion, an unmatched value, a write that must be rejected and non-maskable preemption.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int          NMI_N   = 6;
    localparam int          MSK_N   = 5;
    localparam logic [15:0] VEC_TOP = 16'hFFFE;

    typedef struct packed {
        logic        valid;
        logic        is_reset;
        logic [15:0] vector;
        logic [7:0]  elev;
    } exc_state_t;

    function automatic logic [15:0] vec_of(input int slot);
        return VEC_TOP - 16'(2 * slot);
    endfunction
endpackage

// File: rtl/exc_first_pick.sv
module exc_first_pick #(
    parameter int N = 6,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/exc_mask_pick.sv
module exc_mask_pick #(
    parameter int          M        = 5,
    parameter logic [7:0]  FIRST_LO = 8'hF2,
    localparam int W = (M > 1) ? $clog2(M) : 1
) (
    input  logic [M-1:0] req,
    input  logic [7:0]   elev,
    output logic         any,
    output logic [W-1:0] idx
);
    logic [M-1:0] hit;
    logic         prom_any;
    logic [W-1:0] prom_idx;
    logic         dflt_any;
    logic [W-1:0] dflt_idx;

    for (genvar k = 0; k < M; k++) begin : g_match
        assign hit[k] = (elev == FIRST_LO - 8'(2 * k));
    end

    exc_first_pick #(.N(M)) u_prom (
        .req (hit & req),
        .any (prom_any),
        .idx (prom_idx)
    );

    exc_first_pick #(.N(M)) u_dflt (
        .req (req),
        .any (dflt_any),
        .idx (dflt_idx)
    );

    assign any = dflt_any;
    assign idx = prom_any ? prom_idx : dflt_idx;
endmodule

// File: rtl/exc_resolver.sv
module exc_resolver
    import exc_pkg::*;
#(
    parameter int         RST_N    = 3,
    parameter logic [7:0] ELEV_RST = 8'hF2,
    localparam int NW       = $clog2(NMI_N),
    localparam int MW       = $clog2(MSK_N),
    localparam int XIRQ_IDX = NMI_N - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NMI_N-1:0] nmi_req,
    input  logic [MSK_N-1:0] irq_req,
    input  logic [MSK_N-1:0] irq_en,
    input  logic             mask_i,
    input  logic             mask_x,
    input  logic             elev_we,
    input  logic [7:0]       elev_wdata,
    output logic             exc_valid,
    output logic             exc_is_reset,
    output logic [15:0]      exc_vector
);
    localparam logic [15:0] FIRST_MSK_VEC = VEC_TOP - 16'(2 * NMI_N);

    exc_state_t st_d, st_q;

    logic [NMI_N-1:0] nmi_eff;
    logic [MSK_N-1:0] msk_eff;
    logic             nmi_any, msk_any;
    logic [NW-1:0]    nmi_idx;
    logic [MW-1:0]    msk_idx;

    always_comb begin
        nmi_eff           = nmi_req;
        nmi_eff[XIRQ_IDX] = nmi_req[XIRQ_IDX] & ~mask_x;
        msk_eff           = irq_req & irq_en & {MSK_N{~mask_i}};
    end

    exc_first_pick #(.N(NMI_N)) u_nmi (
        .req (nmi_eff),
        .any (nmi_any),
        .idx (nmi_idx)
    );

    exc_mask_pick #(.M(MSK_N), .FIRST_LO(FIRST_MSK_VEC[7:0])) u_msk (
        .req  (msk_eff),
        .elev (st_q.elev),
        .any  (msk_any),
        .idx  (msk_idx)
    );

    always_comb begin
        st_d          = st_q;
        st_d.valid    = nmi_any | msk_any;
        st_d.is_reset = nmi_any && (int'(nmi_idx) < RST_N);
        if (nmi_any)      st_d.vector = vec_of(int'(nmi_idx));
        else if (msk_any) st_d.vector = vec_of(NMI_N + int'(msk_idx));
        else              st_d.vector = '0;
        if (elev_we && mask_i) st_d.elev = elev_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid    <= 1'b0;
            st_q.is_reset <= 1'b0;
            st_q.vector   <= '0;
            st_q.elev     <= ELEV_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_valid    = st_q.valid;
    assign exc_is_reset = st_q.is_reset;
    assign exc_vector   = st_q.vector;
endmodule

// File: rtl/exc_resolver_chk.sv
module exc_resolver_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  nmi_req,
    input logic [4:0]  irq_req,
    input logic        mask_i,
    input logic        mask_x,
    input logic        exc_valid,
    input logic        exc_is_reset,
    input logic [15:0] exc_vector,
    input logic [7:0]  elev_q
);
    AST_RESET_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        exc_is_reset |-> exc_valid); // R10

    AST_VECTOR_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_vector[15:7] == 9'h1FF && !exc_vector[0])); // R11

    AST_IDLE_VECTOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> exc_vector == 16'h0000); // R11

    AST_POR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req[0] |=> (exc_vector == 16'hFFFE && exc_is_reset)); // R2

    AST_NMI_BEATS_MASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|nmi_req[4:0]) |=> (exc_valid && exc_vector >= 16'hFFF6)); // R9

    AST_ALL_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req[4:0] == 5'b0 && !(nmi_req[5] && !mask_x) && mask_i) |=> !exc_valid); // R4

    AST_XIRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req[4:0] == 5'b0 && mask_x && (mask_i || irq_req == 5'b0)) |=> !exc_valid); // R3

    AST_ELEV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_i |=> $stable(elev_q)); // R8
endmodule

bind exc_resolver exc_resolver_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .nmi_req      (nmi_req),
    .irq_req      (irq_req),
    .mask_i       (mask_i),
    .mask_x       (mask_x),
    .exc_valid    (exc_valid),
    .exc_is_reset (exc_is_reset),
    .exc_vector   (exc_vector),
    .elev_q       (st_q.elev)
);

// File: tb/exc_resolver_tb.sv
module exc_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  nmi_req = '0;
    logic [4:0]  irq_req = '0;
    logic [4:0]  irq_en = '0;
    logic        mask_i = 1'b1;
    logic        mask_x = 1'b1;
    logic        elev_we = 1'b0;
    logic [7:0]  elev_wdata = '0;
    logic        exc_valid, exc_is_reset;
    logic [15:0] exc_vector;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_elev = 8'hF2;
    bit done = 0;

    always #5 clk = ~clk;

    exc_resolver u_dut (
        .clk, .rst_n, .nmi_req, .irq_req, .irq_en, .mask_i, .mask_x,
        .elev_we, .elev_wdata, .exc_valid, .exc_is_reset, .exc_vector
    );

    function automatic logic [17:0] model(input logic [5:0] n, input logic [4:0] r,
                                           input logic [4:0] e, input logic mi,
                                           input logic mx, input logic [7:0] el);
        logic [4:0] m;
        int p;
        for (int i = 0; i < 6; i++)
            if (n[i] && !(i == 5 && mx))
                return {1'b1, i < 3, 16'hFFFE - 16'(2 * i)};
        if (mi) return 18'd0;
        m = r & e;
        p = -1;
        for (int k = 0; k < 5; k++)
            if (el == 8'hF2 - 8'(2 * k)) p = k;
        if (p >= 0 && m[p]) return {2'b10, 16'hFFF2 - 16'(2 * p)};
        for (int k = 0; k < 5; k++)
            if (m[k]) return {2'b10, 16'hFFF2 - 16'(2 * k)};
        return 18'd0;
    endfunction

    task automatic compare(input string tag, input logic [17:0] exp);
        checks++;
        if ({exc_valid, exc_is_reset, exc_vector} !== exp) begin
            failures++;
            $display("FAIL %s: got valid=%0b rst=%0b vec=%h, exp valid=%0b rst=%0b vec=%h",
                     tag, exc_valid, exc_is_reset, exc_vector, exp[17], exp[16], exp[15:0]);
        end
    endtask

    // inputs are already driven (after a negedge); cross one posedge and compare
    task automatic step(input string tag);
        logic [17:0] exp;
        exp = model(nmi_req, irq_req, irq_en, mask_i, mask_x, m_elev);
        if (elev_we && mask_i) m_elev = elev_wdata;
        @(negedge clk);
        compare(tag, exp);
    endtask

    task automatic drive(input logic [5:0] n, input logic [4:0] r, input logic [4:0] e,
                         input logic mi, input logic mx);
        nmi_req = n; irq_req = r; irq_en = e; mask_i = mi; mask_x = mx;
        elev_we = 1'b0;
    endtask

    task automatic write_elev(input logic [7:0] v, input logic mi);
        drive('0, '0, '0, mi, 1'b1);
        elev_we = 1'b1; elev_wdata = v;
        step("R8 write");
        elev_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [17:0] exp_prev;
        repeat (3) @(negedge clk);
        compare("R1 reset", 18'd0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 idle", 18'd0);

        drive('0, 5'h1F, 5'h1F, 1'b0, 1'b1); step("R1 default order");
        drive('0, 5'b10010, 5'h1F, 1'b0, 1'b1); step("R5 rti over t2");
        drive('0, 5'b10000, 5'h1F, 1'b0, 1'b1); step("R5 t2 alone");
        for (int i = 0; i < 6; i++) begin
            drive(6'(1 << i), '0, '0, 1'b1, 1'b0); step("R2 single nmi");
        end
        drive(6'b010001, '0, '0, 1'b1, 1'b0); step("R2 por over swi");
        drive(6'b101000, '0, '0, 1'b1, 1'b0); step("R2 trap over xirq");
        drive(6'b100000, '0, '0, 1'b1, 1'b1); step("R3 xirq masked");
        drive(6'b100000, 5'h1F, 5'h1F, 1'b0, 1'b1); step("R3 xirq masked, irq wins");
        drive('0, 5'h1F, 5'h1F, 1'b1, 1'b1); step("R4 I masks");
        drive('0, 5'h1F, 5'h00, 1'b0, 1'b1); step("R4 local enables off");
        drive(6'b010000, '0, '0, 1'b0, 1'b1); step("R4 I no effect on nmi");

        write_elev(8'hEC, 1'b1);
        drive('0, 5'h1F, 5'h1F, 1'b0, 1'b1); step("R6 t1 promoted");
        drive('0, 5'b10100, 5'h1F, 1'b0, 1'b1); step("R6 others keep order");
        drive('0, 5'h1F, 5'b10111, 1'b0, 1'b1); step("R6 promoted still enable-gated");
        drive(6'b010000, 5'h1F, 5'h1F, 1'b0, 1'b1); step("R9 swi over promoted");
        drive(6'b000100, 5'h1F, 5'h1F, 1'b0, 1'b1); step("R10 watchdog is reset");
        drive(6'b001000, 5'h1F, 5'h1F, 1'b0, 1'b1); step("R10 trap not reset");

        write_elev(8'hF0, 1'b0);
        drive('0, 5'h1F, 5'h1F, 1'b0, 1'b1); step("R8 locked write ignored");
        write_elev(8'h55, 1'b1);
        drive('0, 5'h1F, 5'h1F, 1'b0, 1'b1); step("R7 unmatched value");

        // R11: outputs hold until the next rising edge
        drive('0, '0, '0, 1'b1, 1'b1);
        exp_prev = model(6'b0, 5'h1F, 5'h1F, 1'b0, 1'b1, m_elev);
        #1 compare("R11 no early change", exp_prev);
        step("R11 after edge");

        for (int t = 0; t < 4000; t++) begin
            logic [7:0] pick;
            string tag;
            logic [17:0] exp;
            nmi_req = ($urandom % 4 == 0) ? 6'($urandom) : 6'b0;
            irq_req = 5'($urandom);
            irq_en  = 5'($urandom);
            mask_i  = ($urandom % 2 == 0);
            mask_x  = ($urandom % 2 == 0);
            elev_we = ($urandom % 4 == 0);
            pick    = 8'($urandom % 6);
            elev_wdata = (pick < 5) ? 8'hF2 - 8'(2 * pick) : 8'($urandom);
            exp = model(nmi_req, irq_req, irq_en, mask_i, mask_x, m_elev);
            tag = !exp[17] ? "R4 random" : (exp[15:0] >= 16'hFFF4) ? "R9 random" : "R6 random";
            step(tag);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule